// File: doc/BRIEF.md
# Boot program copy engine

This block keeps a short boot program in a small retained SRAM and, on request, copies a run of its words into a processor's instruction memory at one word per clock. The host fills the boot SRAM through an address window in the block's register space. It then sets a source word offset, a destination word address and a length in 32-bit words, and writes the start bit of the control register. The start bit reads as one while the copy runs and falls by itself when the last word is written. In the cycle after that, a one-cycle launch pulse tells the processor to begin executing.

A second control bit arms the engine. While it is set, every wake event from the power-management unit re-runs the same copy with no host action. The boot SRAM has no reset, so the program survives power-down and reset of the engine's logic. The block also holds two pairs of 32-bit registers for a later loader: an external-memory pointer and a byte count for the instruction image, and the same pair for the data image. Each pointer holds physical address bits 35:4, so the images it points to are 16-byte aligned. These registers are stored and read back only.

Register word addresses: 0 source offset, 1 destination, 2 word count, 3 control (bit 0 start/busy, bit 1 arm), 4 instruction pointer, 5 instruction byte count, 6 data pointer, 7 data byte count. The boot SRAM window covers word addresses WIN_BASE to WIN_BASE+SRAM_WORDS-1. Any other address reads zero.

Top module: `bootcopy_engine`

## Requirements
- R1: Writing control bit 0 = 1 while the engine is idle starts a copy, provided the copy is legal (see R9). Control bit 0 reads 1 from the cycle after the start write until the copy ends, then reads 0. Control bit 1 reads back the last value written to it.
- R2: A copy of N words, where N is 1 or more, drives imem_we_o high for N consecutive cycles. The first of these cycles follows the start edge. In cycle i, for i from 0 to N-1, imem_addr_o is (destination+i) modulo 2^IMEM_AW and imem_wdata_o is boot SRAM word source+i.
- R3: launch_o is high for exactly one cycle, the cycle after the last word write. With a word count of 0, the start completes at once: launch_o is high in the cycle after the start edge and no instruction-memory write occurs.
- R4: When control bit 1 is set and the engine is idle, a high wake_i starts the same copy as a start write, using the current register values. When bit 1 is clear, wake_i has no effect.
- R5: A start write or wake_i that arrives while a copy runs is ignored. The copy continues unchanged and produces a single launch. Writes to the source, destination and count registers during a copy are discarded.
- R6: Every boot SRAM word can be written and read back through the window. The SRAM contents are unchanged by rst_n.
- R7: After reset, every register reads 0. Registers 4 to 7 read back the full 32-bit value last written to them.
- R8: A window write while a copy runs leaves the SRAM word unchanged, and err_o is high for one cycle in the cycle after that write.
- R9: A start request (a start write, or an armed wake) with source+count > SRAM_WORDS is rejected. No copy runs, no launch occurs, and err_o is high for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (does not clear the boot SRAM) |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register / window word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| wake_i | input | 1 | Power-management wake event |
| imem_we_o | output | 1 | Instruction memory write enable |
| imem_addr_o | output | IMEM_AW | Instruction memory word address |
| imem_wdata_o | output | DATA_W | Instruction memory write data |
| launch_o | output | 1 | One-cycle processor launch pulse |
| err_o | output | 1 | One-cycle pulse: window write blocked or start rejected |

## Verification
Two collisions are provoked on purpose. In one, a host start write and an armed wake event arrive in the same cycle. In the other, a new start request arrives in the final word cycle of a running copy, while the busy flag is still set. In both cases the bench's behavioural model predicts exactly one copy and one launch pulse. The per-cycle comparison of the instruction-memory port and launch_o against that model shows whether a second copy or a lost word occurred. The bench also issues blocked window writes in the middle of a copy and reads the target word back afterwards, which confirms that the SRAM was untouched.

// File: rtl/bootcopy_pkg.sv
package bootcopy_pkg;
    localparam int unsigned REG_SRC    = 0;
    localparam int unsigned REG_DST    = 1;
    localparam int unsigned REG_CNT    = 2;
    localparam int unsigned REG_CTRL   = 3;
    localparam int unsigned REG_IPTR   = 4;
    localparam int unsigned REG_IBYTES = 5;
    localparam int unsigned REG_DPTR   = 6;
    localparam int unsigned REG_DBYTES = 7;

    localparam int unsigned CTRL_GO_BIT  = 0;
    localparam int unsigned CTRL_ARM_BIT = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_COPY = 1'b1
    } cp_state_e;
endpackage

// File: rtl/boot_sram.sv
module boot_sram #(
    parameter int unsigned WORDS  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    // Retained storage: no reset on purpose.
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/copy_fsm.sv
module copy_fsm
    import bootcopy_pkg::*;
#(
    parameter int unsigned SAW     = 5,
    parameter int unsigned IMEM_AW = 8,
    parameter int unsigned CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [SAW-1:0]     src_i,
    input  logic [IMEM_AW-1:0] dst_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic               busy_o,
    output logic [SAW-1:0]     sram_raddr_o,
    output logic               imem_we_o,
    output logic [IMEM_AW-1:0] imem_addr_o,
    output logic               launch_o
);
    typedef struct packed {
        cp_state_e        st;
        logic [CNT_W-1:0] idx;
        logic             launch;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.launch = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    if (cnt_i == '0) begin
                        fsm_d.launch = 1'b1;
                    end else begin
                        fsm_d.st  = ST_COPY;
                        fsm_d.idx = '0;
                    end
                end
            end
            ST_COPY: begin
                if (fsm_q.idx == cnt_i - CNT_W'(1)) begin
                    fsm_d.st     = ST_IDLE;
                    fsm_d.launch = 1'b1;
                end else begin
                    fsm_d.idx = fsm_q.idx + CNT_W'(1);
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, idx: '0, launch: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign busy_o       = (fsm_q.st == ST_COPY);
    assign imem_we_o    = busy_o;
    assign sram_raddr_o = src_i + fsm_q.idx[SAW-1:0];
    assign imem_addr_o  = dst_i + fsm_q.idx[IMEM_AW-1:0];
    assign launch_o     = fsm_q.launch;
endmodule

// File: rtl/bootcopy_engine.sv
module bootcopy_engine
    import bootcopy_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SRAM_WORDS = 32,
    parameter int unsigned IMEM_AW    = 8,
    parameter int unsigned REG_AW     = 12,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned WIN_BASE   = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               wake_i,
    output logic               imem_we_o,
    output logic [IMEM_AW-1:0] imem_addr_o,
    output logic [DATA_W-1:0]  imem_wdata_o,
    output logic               launch_o,
    output logic               err_o
);
    localparam int unsigned SAW = $clog2(SRAM_WORDS);

    typedef struct packed {
        logic [SAW-1:0]     src;
        logic [IMEM_AW-1:0] dst;
        logic [CNT_W-1:0]   cnt;
        logic               arm;
        logic [DATA_W-1:0]  iptr;
        logic [DATA_W-1:0]  ibytes;
        logic [DATA_W-1:0]  dptr;
        logic [DATA_W-1:0]  dbytes;
        logic               err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             busy;
    logic             win_hit;
    logic [SAW-1:0]   win_idx;
    logic [CNT_W:0]   span;
    logic             too_long;
    logic             host_go;
    logic             req;
    logic             go;
    logic             sram_we;
    logic [SAW-1:0]   copy_raddr;
    logic [DATA_W-1:0] win_rdata;

    assign win_hit  = (int'(reg_addr) >= int'(WIN_BASE)) &&
                      (int'(reg_addr) <  int'(WIN_BASE + SRAM_WORDS));
    assign win_idx  = SAW'(reg_addr - REG_AW'(WIN_BASE));
    assign span     = {1'b0, regs_q.cnt} + (CNT_W+1)'(regs_q.src);
    assign too_long = span > (CNT_W+1)'(SRAM_WORDS);
    assign host_go  = reg_wen && (int'(reg_addr) == int'(REG_CTRL)) &&
                      reg_wdata[CTRL_GO_BIT];
    assign req      = host_go || (wake_i && regs_q.arm);
    assign go       = req && !busy && !too_long;
    assign sram_we  = reg_wen && win_hit && !busy;

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = (reg_wen && win_hit && busy) || (req && !busy && too_long);
        if (reg_wen) begin
            unique case (int'(reg_addr))
                REG_SRC:    if (!busy) regs_d.src = reg_wdata[SAW-1:0];
                REG_DST:    if (!busy) regs_d.dst = reg_wdata[IMEM_AW-1:0];
                REG_CNT:    if (!busy) regs_d.cnt = reg_wdata[CNT_W-1:0];
                REG_CTRL:   regs_d.arm    = reg_wdata[CTRL_ARM_BIT];
                REG_IPTR:   regs_d.iptr   = reg_wdata;
                REG_IBYTES: regs_d.ibytes = reg_wdata;
                REG_DPTR:   regs_d.dptr   = reg_wdata;
                REG_DBYTES: regs_d.dbytes = reg_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (win_hit) begin
            reg_rdata = win_rdata;
        end else begin
            unique case (int'(reg_addr))
                REG_SRC:    reg_rdata = DATA_W'(regs_q.src);
                REG_DST:    reg_rdata = DATA_W'(regs_q.dst);
                REG_CNT:    reg_rdata = DATA_W'(regs_q.cnt);
                REG_CTRL: begin
                    reg_rdata[CTRL_GO_BIT]  = busy;
                    reg_rdata[CTRL_ARM_BIT] = regs_q.arm;
                end
                REG_IPTR:   reg_rdata = regs_q.iptr;
                REG_IBYTES: reg_rdata = regs_q.ibytes;
                REG_DPTR:   reg_rdata = regs_q.dptr;
                REG_DBYTES: reg_rdata = regs_q.dbytes;
                default:    reg_rdata = '0;
            endcase
        end
    end

    boot_sram #(
        .WORDS  (SRAM_WORDS),
        .DATA_W (DATA_W)
    ) u_sram (
        .clk     (clk),
        .we      (sram_we),
        .waddr   (win_idx),
        .wdata   (reg_wdata),
        .raddr_a (win_idx),
        .rdata_a (win_rdata),
        .raddr_b (copy_raddr),
        .rdata_b (imem_wdata_o)
    );

    copy_fsm #(
        .SAW     (SAW),
        .IMEM_AW (IMEM_AW),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .src_i        (regs_q.src),
        .dst_i        (regs_q.dst),
        .cnt_i        (regs_q.cnt),
        .busy_o       (busy),
        .sram_raddr_o (copy_raddr),
        .imem_we_o    (imem_we_o),
        .imem_addr_o  (imem_addr_o),
        .launch_o     (launch_o)
    );

    assign err_o = regs_q.err;
endmodule

// File: rtl/bootcopy_chk.sv
module bootcopy_chk
    import bootcopy_pkg::*;
#(
    parameter int unsigned SRAM_WORDS = 32,
    parameter int unsigned IMEM_AW    = 8,
    parameter int unsigned REG_AW     = 12,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned WIN_BASE   = 256,
    localparam int unsigned SAW       = $clog2(SRAM_WORDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wen,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               busy,
    input logic               imem_we,
    input logic [IMEM_AW-1:0] imem_addr,
    input logic               launch,
    input logic               err,
    input logic [SAW-1:0]     src_q,
    input logic [CNT_W-1:0]   cnt_q
);
    logic in_win;
    logic ctrl_go_wr;
    logic over;
    assign in_win     = (int'(reg_addr) >= int'(WIN_BASE)) &&
                        (int'(reg_addr) <  int'(WIN_BASE + SRAM_WORDS));
    assign ctrl_go_wr = reg_wen && (int'(reg_addr) == int'(REG_CTRL)) &&
                        reg_wdata[CTRL_GO_BIT];
    assign over       = (int'(cnt_q) + int'(src_q)) > int'(SRAM_WORDS);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && $past(imem_we)) |-> (imem_addr == $past(imem_addr) + IMEM_AW'(1)));

    // R3
    launch_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> launch);

    // R8
    blocked_win_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && in_win && busy) |=> err);

    // R5
    src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wen && (int'(reg_addr) == int'(REG_SRC))) |=> $stable(src_q));

    // R9
    reject_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctrl_go_wr && over) |=> (!busy && !launch && err));
endmodule

bind bootcopy_engine bootcopy_chk #(
    .SRAM_WORDS (SRAM_WORDS),
    .IMEM_AW    (IMEM_AW),
    .REG_AW     (REG_AW),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .WIN_BASE   (WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .imem_we   (imem_we_o),
    .imem_addr (imem_addr_o),
    .launch    (launch_o),
    .err       (err_o),
    .src_q     (regs_q.src),
    .cnt_q     (regs_q.cnt)
);

// File: tb/tb_bootcopy_engine.sv
module tb_bootcopy_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 32;
    localparam int IDEPTH     = 256;
    localparam int WBASE      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_i = 1'b0;
    logic        imem_we_o;
    logic [7:0]  imem_addr_o;
    logic [31:0] imem_wdata_o;
    logic        launch_o;
    logic        err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootcopy_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_i(wake_i),
        .imem_we_o(imem_we_o), .imem_addr_o(imem_addr_o),
        .imem_wdata_o(imem_wdata_o), .launch_o(launch_o), .err_o(err_o)
    );

    // Behavioural reference model
    logic [31:0] m_sram [WORDS];
    bit          m_ok   [WORDS];
    int          m_src, m_dst, m_cnt, m_idx;
    bit          m_en, m_busy, m_launch, m_err;
    logic [31:0] m_ptr [4];

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    int cyc = 0;
    int launches = 0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_sram[i] = '0; m_ok[i] = 0; end
        m_src = 0; m_dst = 0; m_cnt = 0; m_idx = 0;
        m_en = 0; m_busy = 0; m_launch = 0; m_err = 0;
        for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_cnt = 0; m_idx = 0;
            m_en = 0; m_busy = 0; m_launch = 0; m_err = 0;
            for (int i = 0; i < 4; i++) m_ptr[i] = '0;
        end else begin
            bit b0, en0, req;
            int a;
            b0 = m_busy; en0 = m_en;
            m_launch = 0; m_err = 0;
            if (b0) begin
                if (m_idx == m_cnt - 1) begin m_busy = 0; m_launch = 1; end
                else m_idx++;
            end
            a = int'(reg_addr);
            req = wake_i && en0;
            if (reg_wen) begin
                if (a >= WBASE && a < WBASE + WORDS) begin
                    if (b0) m_err = 1;
                    else begin m_sram[a-WBASE] = reg_wdata; m_ok[a-WBASE] = 1; end
                end else if (a == 0) begin if (!b0) m_src = int'(reg_wdata) % WORDS; end
                else if (a == 1) begin if (!b0) m_dst = int'(reg_wdata) % IDEPTH; end
                else if (a == 2) begin if (!b0) m_cnt = int'(reg_wdata[15:0]); end
                else if (a == 3) begin m_en = reg_wdata[1]; if (reg_wdata[0]) req = 1; end
                else if (a >= 4 && a <= 7) m_ptr[a-4] = reg_wdata;
            end
            if (req && !b0) begin
                if (m_cnt + m_src > WORDS) m_err = 1;
                else if (m_cnt == 0) m_launch = 1;
                else begin m_busy = 1; m_idx = 0; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            int a;
            logic [31:0] er;
            bit rd_known;
            chk("R2 imem_we", {31'b0, imem_we_o}, {31'b0, m_busy});
            if (m_busy) begin
                chk("R2 imem_addr", {24'b0, imem_addr_o}, 32'((m_dst + m_idx) % IDEPTH));
                chk("R2 imem_wdata", imem_wdata_o, m_sram[(m_src + m_idx) % WORDS]);
            end
            chk("R3 launch", {31'b0, launch_o}, {31'b0, m_launch});
            chk("R8 or R9 err", {31'b0, err_o}, {31'b0, m_err});
            a = int'(reg_addr);
            rd_known = 1;
            er = '0;
            if (a >= WBASE && a < WBASE + WORDS) begin
                rd_known = m_ok[a-WBASE]; er = m_sram[a-WBASE];
            end else if (a == 0) er = 32'(m_src);
            else if (a == 1) er = 32'(m_dst);
            else if (a == 2) er = 32'(m_cnt);
            else if (a == 3) er = {30'b0, m_en, m_busy};
            else if (a >= 4 && a <= 7) er = m_ptr[a-4];
            if (rd_known) begin
                if (a == 3) chk("R1 ctrl readback", reg_rdata, er);
                else if (a >= WBASE) chk("R6 window readback", reg_rdata, er);
                else chk("R7 register readback", reg_rdata, er);
            end
        end
    end

    always @(posedge clk) if (launch_o) launches++;

    task automatic fin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            fin();
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wen = 1'b1; reg_addr = 12'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd(input int a);
        @(posedge clk); #1;
        reg_addr = 12'(a);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wake_pulse();
        @(posedge clk); #1; wake_i = 1'b1;
        @(posedge clk); #1; wake_i = 1'b0;
    endtask

    task automatic setup(input int s, input int d, input int c);
        wr(0, 32'(s)); wr(1, 32'(d)); wr(2, 32'(c));
    endtask

    initial begin
        int l0;
        idle(3);
        #1 rst_n = 1'b1;
        idle(1); #1 cmp_on = 1;
        // R7: reset values of every register
        for (int a = 0; a < 9; a++) rd(a);
        // R6: fill and read back the boot SRAM
        for (int i = 0; i < WORDS; i++) wr(WBASE + i, 32'hB000_0000 + 32'(i) * 32'h0101);
        for (int i = 0; i < WORDS; i += 5) rd(WBASE + i);
        // R1 R2 R3: plain copy, poll control during it
        setup(2, 16, 5);
        wr(3, 32'h1);
        rd(3); idle(8);
        // R3: zero-length copy launches at once
        setup(4, 40, 0);
        l0 = launches;
        wr(3, 32'h1); idle(3);
        chk("R3 zero-length launch count", 32'(launches - l0), 32'd1);
        // R9: rejected starts
        setup(30, 0, 3); wr(3, 32'h1); idle(3);
        setup(0, 0, 33); wr(3, 32'h1); idle(3);
        // R2: full-size copy wrapping the destination
        setup(0, 240, 32); wr(3, 32'h1);
        // R5 R8: disturbances during the copy
        wr(3, 32'h1);
        wr(0, 32'd7);
        wr(2, 32'd3);
        wr(WBASE + 3, 32'hDEAD_BEEF);
        wake_pulse();
        idle(30);
        rd(WBASE + 3); rd(0); rd(2);
        // R4: wake without arm, then armed wakes
        setup(1, 8, 4);
        wake_pulse(); idle(6);
        wr(3, 32'h2); rd(3);
        wake_pulse(); idle(2);
        wake_pulse(); idle(8);
        wake_pulse(); idle(8);
        // R5: start write in the last word cycle of a copy
        setup(3, 100, 2);
        wr(3, 32'h3);
        wr(3, 32'h3);
        idle(6);
        // wake and start in the same cycle: one copy only
        setup(5, 60, 3);
        l0 = launches;
        @(posedge clk); #1;
        wake_i = 1'b1; reg_wen = 1'b1; reg_addr = 12'(3); reg_wdata = 32'h3;
        @(posedge clk); #1;
        wake_i = 1'b0; reg_wen = 1'b0;
        idle(8);
        chk("R5 single launch on coincident requests", 32'(launches - l0), 32'd1);
        // R4: armed wake that is rejected
        setup(31, 0, 2); wake_pulse(); idle(3);
        // R7: pointer and byte-count registers
        wr(4, 32'h0ABC_DEF1); wr(5, 32'h0000_1234);
        wr(6, 32'hFFFF_FFF0); wr(7, 32'h8000_0001);
        for (int a = 4; a < 8; a++) rd(a);
        // R6: retention across reset
        @(posedge clk); #1 cmp_on = 0; rst_n = 1'b0;
        idle(2); #1 rst_n = 1'b1;
        idle(1); #1 cmp_on = 1;
        for (int i = 0; i < WORDS; i += 3) rd(WBASE + i);
        for (int a = 0; a < 8; a++) rd(a);
        idle(2);
        fin();
    end
endmodule